// File: doc/BRIEF.md
# Frequent-value candidate table

This block keeps a small per-node record of the data values that come up most often among the units that a compressor could not encode. The compressor offers each such unit to the table. If the unit's value is already held, that entry's hit counter goes up. If the value is not held, the value takes a slot. An empty slot is used first. When no slot is empty, the slot with the fewest hits is replaced. The table is off the critical path, and it accepts at most one unit per clock.

From time to time, a gathering agent reads out every slot through an indexed read port. The agent uses the value and hit count of each slot to rebuild the shared pattern set. A clear input empties the table for the next gathering period. The width of a unit is set by a parameter in bytes, so one design serves word, quarter-line and full-line units.

Top module: `freq_candidate_table`

## Requirements
- R1: After reset, and in the cycle after `clear_i` is high, every slot reads back with used flag 0 and hit count 0.
- R2: A cycle with `unit_vld_i` low and `clear_i` low leaves every slot's used flag, value and count unchanged, whatever `unit_i` holds.
- R3: An offered unit whose value equals a used slot's value increments that slot's count by one in the next cycle. A used slot never has count 0.
- R4: A hit count that has reached its maximum, 2^CNT_W-1, stays at that maximum on further hits.
- R5: An offered unit that matches no slot, while at least one slot is unused, is written into the unused slot with the lowest index, with count 1.
- R6: An offered unit that matches no slot, while all slots are used, replaces the slot with the smallest count. On a tie, the lowest index is chosen. The new count is 1.
- R7: When `clear_i` and `unit_vld_i` are high in the same cycle, the clear wins and the table ends up empty.
- R8: A read request at index `rd_idx_i` makes `rd_vld_o` high in the next cycle. In that cycle, `rd_used_o`, `rd_value_o` and `rd_count_o` show that slot as it stood before any update in the request cycle. Without a request, `rd_vld_o` is low.
- R9: Units offered in consecutive cycles each take effect. Apart from a clear, at most one slot changes per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Empty the table |
| unit_vld_i | input | 1 | An uncompressed unit is offered this cycle |
| unit_i | input | UNIT_W | Value of the offered unit (UNIT_BYTES*8 bits) |
| rd_req_i | input | 1 | Read-out request |
| rd_idx_i | input | IDX_W | Slot to read ($clog2(ENTRIES) bits) |
| rd_vld_o | output | 1 | Read result valid |
| rd_used_o | output | 1 | Read slot holds a value |
| rd_value_o | output | UNIT_W | Read slot value |
| rd_count_o | output | CNT_W | Read slot hit count |

## Verification
The assertions check the following on every cycle:
- a clear empties the table;
- idle cycles change nothing;
- a used slot never has count 0;
- a newly filled slot starts at 1;
- a saturated count either stays at its maximum or restarts at 1 on replacement;
- at most one slot changes per cycle;
- the read response comes exactly one cycle after its request.

Only the bench's scenarios can show the following:
- which slot a miss chooses when slots are free or tied;
- that a hit lands on the matching value;
- that a clear overrides a simultaneous unit;
- that a read shows the contents from before the same-cycle update.

// File: rtl/cand_pkg.sv
package cand_pkg;
    // Kind of table update chosen for the current cycle
    typedef enum logic [1:0] {
        UPD_IDLE  = 2'd0,
        UPD_HIT   = 2'd1,
        UPD_FILL  = 2'd2,
        UPD_EVICT = 2'd3
    } upd_e;
endpackage

// File: rtl/cand_match_bank.sv
module cand_match_bank #(
    parameter int ENTRIES = 4,
    parameter int UNIT_W  = 32,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0]             valid_i,
    input  logic [ENTRIES-1:0][UNIT_W-1:0] value_i,
    input  logic [UNIT_W-1:0]              unit_i,
    output logic                           hit_o,
    output logic [IDX_W-1:0]               hit_idx_o
);
    logic [ENTRIES-1:0] hit_vec;

    // One comparator per slot
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign hit_vec[g] = valid_i[g] && (value_i[g] == unit_i);
    end

    always_comb begin
        hit_idx_o = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                hit_idx_o = IDX_W'(i);
            end
        end
    end

    assign hit_o = |hit_vec;
endmodule

// File: rtl/cand_victim_pick.sv
module cand_victim_pick #(
    parameter int ENTRIES = 4,
    parameter int CNT_W   = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0]            valid_i,
    input  logic [ENTRIES-1:0][CNT_W-1:0] count_i,
    output logic                          free_o,
    output logic [IDX_W-1:0]              victim_idx_o
);
    logic [IDX_W-1:0] free_idx;
    logic [IDX_W-1:0] min_idx;
    logic [CNT_W-1:0] min_cnt;

    // Lowest-index unused slot
    always_comb begin
        free_o   = 1'b0;
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_i[i]) begin
                free_o   = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
    end

    // Smallest count; strict compare keeps the lowest index on ties
    always_comb begin
        min_idx = '0;
        min_cnt = count_i[0];
        for (int i = 1; i < ENTRIES; i++) begin
            if (count_i[i] < min_cnt) begin
                min_cnt = count_i[i];
                min_idx = IDX_W'(i);
            end
        end
    end

    assign victim_idx_o = free_o ? free_idx : min_idx;
endmodule

// File: rtl/freq_candidate_table.sv
module freq_candidate_table
    import cand_pkg::*;
#(
    parameter int UNIT_BYTES = 4,
    parameter int ENTRIES    = 4,
    parameter int CNT_W      = 8,
    localparam int UNIT_W    = UNIT_BYTES * 8,
    localparam int IDX_W     = $clog2(ENTRIES)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              clear_i,
    input  logic              unit_vld_i,
    input  logic [UNIT_W-1:0] unit_i,
    input  logic              rd_req_i,
    input  logic [IDX_W-1:0]  rd_idx_i,
    output logic              rd_vld_o,
    output logic              rd_used_o,
    output logic [UNIT_W-1:0] rd_value_o,
    output logic [CNT_W-1:0]  rd_count_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        logic [ENTRIES-1:0]             valid;
        logic [ENTRIES-1:0][UNIT_W-1:0] value;
        logic [ENTRIES-1:0][CNT_W-1:0]  count;
        logic                           rd_vld;
        logic                           rd_used;
        logic [UNIT_W-1:0]              rd_value;
        logic [CNT_W-1:0]               rd_count;
    } state_t;

    localparam state_t RESET_ST = '0;

    state_t st_d, st_q;

    logic [ENTRIES-1:0]             ent_valid;
    logic [ENTRIES-1:0][UNIT_W-1:0] ent_value;
    logic [ENTRIES-1:0][CNT_W-1:0]  ent_count;
    logic                           hit;
    logic [IDX_W-1:0]               hit_idx;
    logic                           has_free;
    logic [IDX_W-1:0]               victim_idx;
    upd_e                           upd;

    assign ent_valid = st_q.valid;
    assign ent_value = st_q.value;
    assign ent_count = st_q.count;

    cand_match_bank #(
        .ENTRIES (ENTRIES),
        .UNIT_W  (UNIT_W)
    ) u_match (
        .valid_i   (ent_valid),
        .value_i   (ent_value),
        .unit_i    (unit_i),
        .hit_o     (hit),
        .hit_idx_o (hit_idx)
    );

    cand_victim_pick #(
        .ENTRIES (ENTRIES),
        .CNT_W   (CNT_W)
    ) u_victim (
        .valid_i      (ent_valid),
        .count_i      (ent_count),
        .free_o       (has_free),
        .victim_idx_o (victim_idx)
    );

    always_comb begin
        if (!unit_vld_i || clear_i) begin
            upd = UPD_IDLE;
        end else if (hit) begin
            upd = UPD_HIT;
        end else if (has_free) begin
            upd = UPD_FILL;
        end else begin
            upd = UPD_EVICT;
        end
    end

    always_comb begin
        st_d = st_q;

        // Read path samples the pre-update contents
        st_d.rd_vld   = rd_req_i;
        st_d.rd_used  = rd_req_i ? st_q.valid[rd_idx_i] : 1'b0;
        st_d.rd_value = rd_req_i ? st_q.value[rd_idx_i] : '0;
        st_d.rd_count = rd_req_i ? st_q.count[rd_idx_i] : '0;

        unique case (upd)
            UPD_HIT: begin
                if (st_q.count[hit_idx] != CNT_MAX) begin
                    st_d.count[hit_idx] = st_q.count[hit_idx] + CNT_ONE;
                end
            end
            UPD_FILL, UPD_EVICT: begin
                st_d.valid[victim_idx] = 1'b1;
                st_d.value[victim_idx] = unit_i;
                st_d.count[victim_idx] = CNT_ONE;
            end
            default: ;
        endcase

        if (clear_i) begin
            st_d.valid = '0;
            st_d.count = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= RESET_ST;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_vld_o   = st_q.rd_vld;
    assign rd_used_o  = st_q.rd_used;
    assign rd_value_o = st_q.rd_value;
    assign rd_count_o = st_q.rd_count;
endmodule

// File: rtl/cand_table_checker.sv
module cand_table_checker #(
    parameter int ENTRIES = 4,
    parameter int UNIT_W  = 32,
    parameter int CNT_W   = 8
) (
    input logic                           clk_i,
    input logic                           rst_ni,
    input logic                           clear_i,
    input logic                           unit_vld_i,
    input logic                           rd_req_i,
    input logic                           rd_vld_o,
    input logic [ENTRIES-1:0]             valid_i,
    input logic [ENTRIES-1:0][UNIT_W-1:0] value_i,
    input logic [ENTRIES-1:0][CNT_W-1:0]  count_i
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [ENTRIES-1:0]             prev_valid;
    logic [ENTRIES-1:0][UNIT_W-1:0] prev_value;
    logic [ENTRIES-1:0][CNT_W-1:0]  prev_count;
    logic [ENTRIES-1:0]             chg;

    always_ff @(posedge clk_i) begin
        prev_valid <= valid_i;
        prev_value <= value_i;
        prev_count <= count_i;
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        assign chg[g] = (valid_i[g] != prev_valid[g]) ||
                        (value_i[g] != prev_value[g]) ||
                        (count_i[g] != prev_count[g]);

        AST_NEW_COUNT_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $rose(valid_i[g]) |-> count_i[g] == CNT_W'(1)); // R5
        AST_LIVE_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
            valid_i[g] |-> count_i[g] != '0); // R3
        AST_SAT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (valid_i[g] && count_i[g] == CNT_MAX && !clear_i)
            |=> (count_i[g] == CNT_MAX || count_i[g] == CNT_W'(1))); // R4
    end

    AST_CLEAR_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clear_i |=> (valid_i == '0 && count_i == '0)); // R1
    AST_IDLE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!clear_i && !unit_vld_i) |=> ($stable(valid_i) && $stable(count_i) && $stable(value_i))); // R2
    AST_ONE_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !clear_i |=> $onehot0(chg)); // R9
    AST_RD_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_req_i |=> rd_vld_o); // R8
    AST_RD_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_req_i |=> !rd_vld_o); // R8
endmodule

bind freq_candidate_table cand_table_checker #(
    .ENTRIES (ENTRIES),
    .UNIT_W  (UNIT_W),
    .CNT_W   (CNT_W)
) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (clear_i),
    .unit_vld_i (unit_vld_i),
    .rd_req_i   (rd_req_i),
    .rd_vld_o   (rd_vld_o),
    .valid_i    (ent_valid),
    .value_i    (ent_value),
    .count_i    (ent_count)
);

// File: tb/freq_candidate_table_bench.sv
module freq_candidate_table_bench;
    localparam int UW = 32;
    localparam int CW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clear = 1'b0;
    logic          uvld = 1'b0;
    logic [UW-1:0] unit = '0;
    logic          rreq = 1'b0;
    logic [1:0]    ridx = '0;
    logic          rvld, rused;
    logic [UW-1:0] rval;
    logic [CW-1:0] rcnt;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;  // 50 MHz

    freq_candidate_table #(.UNIT_BYTES(4), .ENTRIES(4), .CNT_W(CW)) u_freq_candidate_table (
        .clk_i(clk), .rst_ni(rst_n), .clear_i(clear), .unit_vld_i(uvld), .unit_i(unit),
        .rd_req_i(rreq), .rd_idx_i(ridx), .rd_vld_o(rvld), .rd_used_o(rused),
        .rd_value_o(rval), .rd_count_o(rcnt)
    );

    typedef struct packed {
        logic [UW-1:0] unit;
        logic [1:0]    idx;
        logic [UW-1:0] exp_val;
        logic [CW-1:0] exp_cnt;
        logic [3:0]    req;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_00A1, 2'd0, 32'h0000_00A1, 3'd1, 4'd5}, // R5 first free slot
        '{32'h0000_00B2, 2'd1, 32'h0000_00B2, 3'd1, 4'd5}, // R5 next free slot
        '{32'h0000_00A1, 2'd0, 32'h0000_00A1, 3'd2, 4'd3}, // R3 hit
        '{32'h0000_00C3, 2'd2, 32'h0000_00C3, 3'd1, 4'd5}, // R5
        '{32'h0000_00D4, 2'd3, 32'h0000_00D4, 3'd1, 4'd5}, // R5 table now full
        '{32'h0000_00B2, 2'd1, 32'h0000_00B2, 3'd2, 4'd3}, // R3 hit
        '{32'h0000_00E5, 2'd2, 32'h0000_00E5, 3'd1, 4'd6}, // R6 tie 2/3, lowest wins
        '{32'h0000_00F6, 2'd2, 32'h0000_00F6, 3'd1, 4'd6}, // R6 tie again
        '{32'h0000_00D4, 2'd3, 32'h0000_00D4, 3'd2, 4'd3}, // R3 hit on slot 3
        '{32'h0000_0017, 2'd2, 32'h0000_0017, 3'd1, 4'd6}  // R6 single minimum
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic offer(input logic [UW-1:0] v);
        @(negedge clk);
        uvld = 1'b1; unit = v;
        @(negedge clk);
        uvld = 1'b0;
    endtask

    task automatic read_slot(input logic [1:0] i);
        @(negedge clk);
        rreq = 1'b1; ridx = i;
        @(negedge clk);
        rreq = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8 idle rd_vld", 64'(rvld), 64'd0);
        // R1 reset state
        for (int i = 0; i < 4; i++) begin
            read_slot(2'(i));
            chk("R8 rd_vld", 64'(rvld), 64'd1);
            chk("R1 reset used", 64'(rused), 64'd0);
            chk("R1 reset count", 64'(rcnt), 64'd0);
        end

        // Vector walk
        for (int k = 0; k < NV; k++) begin
            offer(VECS[k].unit);
            read_slot(VECS[k].idx);
            chk($sformatf("R%0d value v%0d", VECS[k].req, k), 64'(rval), 64'(VECS[k].exp_val));
            chk($sformatf("R%0d count v%0d", VECS[k].req, k), 64'(rcnt), 64'(VECS[k].exp_cnt));
        end

        // R2: data wiggles with valid low
        @(negedge clk);
        unit = 32'h0000_00A1;
        @(negedge clk);
        unit = 32'h0000_9999;
        read_slot(2'd0);
        chk("R2 ignored count", 64'(rcnt), 64'd2);
        read_slot(2'd3);
        chk("R2 ignored value", 64'(rval), 64'h0000_00D4);

        // R1 clear
        @(negedge clk);
        clear = 1'b1;
        @(negedge clk);
        clear = 1'b0;
        read_slot(2'd1);
        chk("R1 clear used", 64'(rused), 64'd0);
        chk("R1 clear count", 64'(rcnt), 64'd0);

        // R9 and R4: back-to-back offers saturate at 7
        @(negedge clk);
        uvld = 1'b1; unit = 32'h0000_0055;
        repeat (9) @(negedge clk);
        uvld = 1'b0;
        read_slot(2'd0);
        chk("R4 saturated count", 64'(rcnt), 64'd7);
        read_slot(2'd1);
        chk("R9 no extra slot", 64'(rused), 64'd0);

        // R7 clear beats a same-cycle unit
        @(negedge clk);
        clear = 1'b1; uvld = 1'b1; unit = 32'h0000_0066;
        @(negedge clk);
        clear = 1'b0; uvld = 1'b0;
        read_slot(2'd0);
        chk("R7 slot0 used", 64'(rused), 64'd0);

        // R8 read shows pre-update contents
        offer(32'h0000_0077);
        @(negedge clk);
        uvld = 1'b1; unit = 32'h0000_0077; rreq = 1'b1; ridx = 2'd0;
        @(negedge clk);
        uvld = 1'b0; rreq = 1'b0;
        chk("R8 snapshot count", 64'(rcnt), 64'd1);
        read_slot(2'd0);
        chk("R8 after update", 64'(rcnt), 64'd2);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule